// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block runs an eight-pin general-purpose I/O port. Each pin can be owned by the port itself or handed to an alternate chip-select function. Software sees two 16-bit registers on a simple synchronous bus. The first is a combined word: the direction bits sit in the upper byte and the data bits in the lower byte. The second is a word of per-pin select bits. Byte strobes let the direction half and the data half be written on their own.

When a pin's select bit is set, the port owns the pin: the direction bit drives the pad output enable and the data bit drives the pad level. When the select bit is clear, the alternate function's output and enable pass straight through, and the port's data bit for that pin is forced to zero. Pad levels enter through a two-flop synchronizer. Reads of the data byte report the live, synchronized pad level rather than the stored latch. The synchronized level is also handed to the alternate function.

Top module: `gpio_mux_port`

## Requirements
- R1: While reset is high, pad_oe and pad_out are 0. After reset, both registers read 0x0000.
- R2: The direction/data word is at address 0x438. A write with bus_be[1] loads direction from bits 15:8, and a write with bus_be[0] loads data from bits 7:0. A lane whose strobe is low keeps its value.
- R3: The select word is at address 0x43A. Bits 7:0 are loaded only when bus_be[0] is set. Bits 15:8 always read zero.
- R4: For a pin whose select bit is 1, pad_oe equals its direction bit and pad_out equals its data bit. Both appear one clock after the register changes.
- R5: For a pin whose select bit is 0, pad_out equals alt_out and pad_oe equals alt_oe, registered by one clock. The direction bit has no effect on that pin.
- R6: A data value written while the pin is an input is kept. That value drives the pad once the direction bit is set to 1.
- R7: Bits 7:0 of a direction/data read return the pad level after a two-flop synchronizer, not the stored data bit.
- R8: While a pin's select bit is 0, its data bit is held at 0. Data writes to that pin are dropped, and its bit in a direction/data read is 0.
- R9: bus_rdata is valid one clock after a bus_rd request and is 0 in any cycle that follows no request. A read issued in the same cycle as a write to the same word returns the contents from before the write.
- R10: alt_in carries the synchronized pad level of every pin, whatever its select bit.
- R11: Writes to any other address change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register address |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_be | input | 2 | Byte strobes (bit 1 = upper byte, bit 0 = lower byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| pad_in | input | 8 | Level seen at each pad |
| pad_out | output | 8 | Level driven to each pad |
| pad_oe | output | 8 | Output enable for each pad |
| alt_out | input | 8 | Alternate function output level |
| alt_oe | input | 8 | Alternate function output enable |
| alt_in | output | 8 | Synchronized pad level for the alternate function |

## Verification
A read and a write can hit the direction/data word in the same cycle. The bench provokes this by raising bus_rd and bus_wr together, with a direction change in the upper lane. It then judges that the returned word still shows the old direction byte, and that the next read shows the new one. The select bit and the data bit also meet in one cycle when a pin is deselected while it holds a 1. The bench checks that the data bit reads 0 and is not restored when the pin is selected again.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

  typedef enum logic [1:0] {
    HIT_NONE    = 2'd0,
    HIT_DIRDATA = 2'd1,
    HIT_SELECT  = 2'd2
  } reg_hit_e;

  localparam int unsigned LANES = 2;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_mux_regs.sv
module gpio_mux_regs
  import gpio_mux_pkg::*;
#(
  parameter int unsigned NUM_PINS     = 8,
  parameter int unsigned ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] DIRDATA_ADDR = 12'h438,
  parameter logic [ADDR_W-1:0] SELECT_ADDR  = 12'h43A,
  localparam int unsigned WORD_W      = LANES * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [LANES-1:0]    bus_be,
  input  logic [WORD_W-1:0]   bus_wdata,
  input  logic [NUM_PINS-1:0] pin_level,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] dat_q,
  output logic [NUM_PINS-1:0] sel_q,
  output logic [WORD_W-1:0]   bus_rdata
);

  reg_hit_e            hit;
  logic [NUM_PINS-1:0] dir_nxt, dat_nxt, sel_nxt;
  logic [WORD_W-1:0]   rd_mux;
  logic [NUM_PINS-1:0] lo_lane, hi_lane;

  assign lo_lane = bus_wdata[NUM_PINS-1:0];
  assign hi_lane = bus_wdata[WORD_W-1:NUM_PINS];

  always_comb begin
    if (bus_addr == DIRDATA_ADDR)     hit = HIT_DIRDATA;
    else if (bus_addr == SELECT_ADDR) hit = HIT_SELECT;
    else                              hit = HIT_NONE;
  end

  always_comb begin
    sel_nxt = sel_q;
    dir_nxt = dir_q;
    dat_nxt = dat_q;
    if (bus_wr) begin
      if (hit == HIT_SELECT && bus_be[0]) sel_nxt = lo_lane;
      if (hit == HIT_DIRDATA && bus_be[1]) dir_nxt = hi_lane;
      if (hit == HIT_DIRDATA && bus_be[0]) dat_nxt = lo_lane;
    end
    // deselected pins keep a cleared data bit
    dat_nxt = dat_nxt & sel_nxt;
  end

  always_comb begin
    case (hit)
      HIT_DIRDATA: rd_mux = {dir_q, pin_level & sel_q};
      HIT_SELECT:  rd_mux = {{NUM_PINS{1'b0}}, sel_q};
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      dir_q     <= '0;
      dat_q     <= '0;
      bus_rdata <= '0;
    end else begin
      sel_q     <= sel_nxt;
      dir_q     <= dir_nxt;
      dat_q     <= dat_nxt;
      bus_rdata <= bus_rd ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic dir,
  input  logic dat,
  input  logic alt_out,
  input  logic alt_oe,
  output logic pad_out,
  output logic pad_oe
);

  logic out_d, oe_d;

  always_comb begin
    if (sel) begin
      out_d = dat;
      oe_d  = dir;
    end else begin
      out_d = alt_out;
      oe_d  = alt_oe;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
    end else begin
      pad_out <= out_d;
      pad_oe  <= oe_d;
    end
  end

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DIRDATA_ADDR = 12'h438,
  parameter logic [ADDR_W-1:0] SELECT_ADDR  = 12'h43A,
  localparam int unsigned WORD_W     = LANES * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [LANES-1:0]    bus_be,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  input  logic [NUM_PINS-1:0] alt_out,
  input  logic [NUM_PINS-1:0] alt_oe,
  output logic [NUM_PINS-1:0] alt_in
);

  logic [NUM_PINS-1:0] pin_level;
  logic [NUM_PINS-1:0] dir_vec, dat_vec, sel_vec;

  gpio_sync #(
    .WIDTH (NUM_PINS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (pad_in),
    .q  (pin_level)
  );

  gpio_mux_regs #(
    .NUM_PINS    (NUM_PINS),
    .ADDR_W      (ADDR_W),
    .DIRDATA_ADDR(DIRDATA_ADDR),
    .SELECT_ADDR (SELECT_ADDR)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_be   (bus_be),
    .bus_wdata(bus_wdata),
    .pin_level(pin_level),
    .dir_q    (dir_vec),
    .dat_q    (dat_vec),
    .sel_q    (sel_vec),
    .bus_rdata(bus_rdata)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_mux u_pin (
      .clk    (clk),
      .rst    (rst),
      .sel    (sel_vec[p]),
      .dir    (dir_vec[p]),
      .dat    (dat_vec[p]),
      .alt_out(alt_out[p]),
      .alt_oe (alt_oe[p]),
      .pad_out(pad_out[p]),
      .pad_oe (pad_oe[p])
    );
  end

  assign alt_in = pin_level;

endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] DIRDATA_ADDR = 12'h438,
  parameter logic [ADDR_W-1:0] SELECT_ADDR  = 12'h43A
) (
  input logic                  clk,
  input logic                  rst,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_rd,
  input logic [2*NUM_PINS-1:0] bus_rdata,
  input logic [NUM_PINS-1:0]   pad_out,
  input logic [NUM_PINS-1:0]   pad_oe,
  input logic [NUM_PINS-1:0]   alt_out,
  input logic [NUM_PINS-1:0]   alt_oe,
  input logic [NUM_PINS-1:0]   sel_vec,
  input logic [NUM_PINS-1:0]   dir_vec,
  input logic [NUM_PINS-1:0]   dat_vec
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (pad_oe == '0 && pad_out == '0 && bus_rdata == '0));

  assert_sel_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == SELECT_ADDR) |-> bus_rdata[2*NUM_PINS-1:NUM_PINS] == '0);

  assert_oe_route_R4_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pad_oe == $past((sel_vec & dir_vec) | (~sel_vec & alt_oe)));

  assert_out_route_R4_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pad_out == $past((sel_vec & dat_vec) | (~sel_vec & alt_out)));

  assert_desel_data_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (dat_vec & ~sel_vec) == '0);

  assert_read_old_dir_R9: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == DIRDATA_ADDR) |->
      bus_rdata[2*NUM_PINS-1:NUM_PINS] == $past(dir_vec));

  assert_idle_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(bus_rd) |-> bus_rdata == '0);

endmodule

bind gpio_mux_port gpio_mux_port_chk #(
  .NUM_PINS    (NUM_PINS),
  .ADDR_W      (ADDR_W),
  .DIRDATA_ADDR(DIRDATA_ADDR),
  .SELECT_ADDR (SELECT_ADDR)
) u_chk (.*);

// File: tb/tb_gpio_mux_port.sv
`timescale 1ns/1ps
module tb_gpio_mux_port;

  localparam logic [11:0] A_DD  = 12'h438;
  localparam logic [11:0] A_SEL = 12'h43A;
  localparam logic [7:0]  ALT_O = 8'hA5;
  localparam logic [7:0]  ALT_E = 8'h3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  pad_in, pad_out, pad_oe, alt_in;
  logic [7:0]  ext_in = 8'h5A;
  logic [7:0]  alt_out = ALT_O, alt_oe = ALT_E;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // pad model: a driven pad reads back its own level, otherwise the outside world
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_in);

  gpio_mux_port dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in)
  );

  typedef struct packed {
    logic [11:0] addr;
    logic [1:0]  be;
    logic [15:0] wdata;
    logic [7:0]  oe;
    logic [7:0]  out;
    logic [15:0] dd;
    logic [15:0] sel;
  } vec_t;

  // R2, R3, R4, R5, R8, R11 walked in order; each row's expectation follows the previous row's state
  localparam vec_t VECS [9] = '{
    '{A_SEL,    2'b01, 16'h00FF, 8'h00, 8'h00, 16'h005A, 16'h00FF},
    '{A_DD,     2'b10, 16'hF000, 8'hF0, 8'h00, 16'hF00A, 16'h00FF},
    '{A_DD,     2'b01, 16'h00C3, 8'hF0, 8'hC3, 16'hF0CA, 16'h00FF},
    '{A_DD,     2'b11, 16'h0F3C, 8'h0F, 8'h3C, 16'h0F5C, 16'h00FF},
    '{A_SEL,    2'b01, 16'h000F, 8'h3F, 8'hAC, 16'h0F0C, 16'h000F},
    '{A_DD,     2'b01, 16'h00FF, 8'h3F, 8'hAF, 16'h0F0F, 16'h000F},
    '{A_SEL,    2'b10, 16'hFF00, 8'h3F, 8'hAF, 16'h0F0F, 16'h000F},
    '{12'h43C,  2'b11, 16'hFFFF, 8'h3F, 8'hAF, 16'h0F0F, 16'h000F},
    '{A_SEL,    2'b01, 16'h00FF, 8'h0F, 8'h0F, 16'h0F5F, 16'h00FF}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  logic [15:0] rd;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pad_oe in reset", {8'h0, pad_oe}, 16'h0000);
    check("R1 pad_out in reset", {8'h0, pad_out}, 16'h0000);
    rst = 1'b0;
    settle();
    check("R5 oe follows alt", {8'h0, pad_oe}, {8'h0, ALT_E});
    check("R5 out follows alt", {8'h0, pad_out}, {8'h0, ALT_O});
    check("R10 alt_in level", {8'h0, alt_in}, 16'h0066);
    bus_read(A_DD, rd);  check("R1 dirdata after reset", rd, 16'h0000);
    bus_read(A_SEL, rd); check("R1 select after reset", rd, 16'h0000);
    @(negedge clk);
    check("R9 idle rdata zero", bus_rdata, 16'h0000);

    for (int i = 0; i < 9; i++) begin
      bus_write(VECS[i].addr, VECS[i].be, VECS[i].wdata);
      settle();
      check($sformatf("R4/R5 oe row %0d", i), {8'h0, pad_oe}, {8'h0, VECS[i].oe});
      check($sformatf("R4/R5 out row %0d", i), {8'h0, pad_out}, {8'h0, VECS[i].out});
      bus_read(A_DD, rd);
      check($sformatf("R2/R7/R8/R11 dirdata row %0d", i), rd, VECS[i].dd);
      bus_read(A_SEL, rd);
      check($sformatf("R3/R11 select row %0d", i), rd, VECS[i].sel);
    end

    // R6: data written to an input is kept, then driven when made an output
    bus_write(A_DD, 2'b11, 16'h0096);
    settle();
    check("R6 input not driven", {8'h0, pad_oe}, 16'h0000);
    bus_read(A_DD, rd);
    check("R7 read live level not latch", rd, 16'h005A);
    bus_write(A_DD, 2'b10, 16'hFF00);
    settle();
    check("R6 latched data driven", {8'h0, pad_out}, 16'h0096);
    check("R6 oe after dir set", {8'h0, pad_oe}, 16'h00FF);
    bus_read(A_DD, rd);
    check("R6 readback driven", rd, 16'hFF96);

    // R9: read and write of the same word in one cycle
    @(negedge clk);
    bus_addr = A_DD; bus_be = 2'b10; bus_wdata = 16'h0000; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    rd = bus_rdata;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_be = '0;
    check("R9 same-cycle read old", rd, 16'hFF96);
    settle();
    bus_read(A_DD, rd);
    check("R9 next read new", rd, 16'h005A);

    // R7 / R10: live level changes through the synchronizer
    ext_in = 8'hC3;
    settle();
    bus_read(A_DD, rd);
    check("R7 live level change", rd, 16'h00C3);
    check("R10 alt_in follows pad", {8'h0, alt_in}, 16'h00C3);

    // R8: deselect a pin holding 1, reselect, bit stays 0
    bus_write(A_DD, 2'b11, 16'hFF01);
    bus_write(A_SEL, 2'b01, 16'h00FE);
    bus_write(A_SEL, 2'b01, 16'h00FF);
    settle();
    check("R8 data cleared by deselect", {8'h0, pad_out}, 16'h0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule